// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit configuration registers for a clock synthesiser. The bank has six registers by default. Its contents are always present on a parallel output bus, so the rest of the chip can decode enables and selections from them directly. The slave answers only at device address 0x69. An address byte of 0xD2 starts a write and an address byte of 0xD3 starts a read.

The block has no register pointer. In a write, the host sends a command byte and then a length byte. The slave acknowledges both and discards them. Every data byte after that goes into the next register, starting at register 0. In a read, the slave first returns a length byte equal to the register count and then returns the registers in ascending order. The host may end a transfer after any whole byte.

SCL and SDA are sampled by a system clock that runs much faster than the serial bit rate. The bit rate is standard mode, 100 kbit/s or less. The block never drives SDA high. It only requests a low level through an open-drain style pull output.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged: the slave pulls SDA low during the ninth clock. Address bits are in bits 7..1 of the byte, and bit 0 is the read flag.
- R2: Any other address byte is not acknowledged. Until the next START the slave pulls SDA at no time and changes no register.
- R3: In a write, the two bytes after the address are acknowledged and have no effect on any register.
- R4: In a write, data byte number k (counted from 0) is acknowledged and stored in register k for k below 6. Register k appears on `cfg_regs[8k+7:8k]`.
- R5: STOP ends loading. Registers the transfer did not reach keep their values. A byte cut off by STOP before its eighth bit is not stored.
- R6: In a write, data bytes after the sixth are acknowledged and discarded.
- R7: A read returns the value 6 first and then registers 0 to 5, each byte MSB first. A byte position beyond the last register reads as 0xFF.
- R8: When the host does not acknowledge a byte during a read, the slave releases SDA and stays silent until the next START.
- R9: After reset, register 0 is 0x00 and registers 1 to 5 are 0xFF.
- R10: Every write starts again at register 0, whatever earlier transfers did.
- R11: A repeated START inside a transfer restarts the address phase. A write cut short by it keeps the whole bytes already stored.
- R12: The SDA pull changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of host and slave) |
| sda_pull_low | output | 1 | 1 requests that SDA be pulled low |
| cfg_regs | output | 48 | Register bank, register k in bits 8k+7..8k |

## Verification
The hardest situations to reach are those where a STOP or repeated START arrives at a byte boundary the slave has not yet committed. One case is a write cut off after three bits of a data byte. Another is a repeated START that turns a half-finished write into a read. The bench drives a wired-AND bus model bit by bit, so it can stop the serial clock after any number of bits. It mixes these directed cuts with seeded random transfers of every length: writes with zero to eight data bytes, reads that end at random positions, and writes that end in a partial byte. A model of the register image, kept in the bench, checks each readback.

// File: rtl/clkcfg_pkg.sv
// Shared types for the block-transfer configuration slave.
package clkcfg_pkg;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,     // not addressed; ignore bus until START
        ST_RX,       // shifting in address or write bytes
        ST_RX_ACK,   // slave holding acknowledge low
        ST_TX,       // shifting out a read byte
        ST_TX_ACK    // host acknowledge slot of a read byte
    } link_state_e;

    typedef logic [7:0] octet_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
// Synchronises SCL and SDA into the system clock domain and derives
// edge and bus-condition events. Assumes the system clock is many times
// faster than SCL so each line is stable for several samples per phase.
module i2c_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now_q;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_raw, sda_raw};

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift chain for metastability filtering; idle bus level is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[ln]};
        end
        assign now_q[ln] = chain[STAGES-1];
    end

    // One-sample history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= now_q;
    end

    assign scl_lvl   = now_q[1];
    assign sda_lvl   = now_q[0];
    assign scl_rise  = now_q[1] & ~prev_q[1];
    assign scl_fall  = ~now_q[1] & prev_q[1];
    assign start_evt = now_q[1] & prev_q[1] & ~now_q[0] & prev_q[0];
    assign stop_evt  = now_q[1] & prev_q[1] & now_q[0] & ~prev_q[0];

endmodule

// File: rtl/cfg_link_fsm.sv
// Byte-level protocol engine: address match, block write with two
// discarded header bytes, block read that returns a count first.
// Assumes events from i2c_bus_sampler; changes SDA only after SCL falls.
module cfg_link_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int NUM_REGS = 6,
    parameter int REG_IW   = 3,
    parameter int IDX_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_lvl,
    input  logic                  sda_lvl,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_evt,
    input  logic                  stop_evt,
    input  logic [8*NUM_REGS-1:0] reg_flat,
    output logic                  wr_en,
    output logic [REG_IW-1:0]     wr_sel,
    output octet_t                wr_byte,
    output logic                  sda_pull
);
    localparam int HDR_BYTES = 2;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] DATA_LO = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] DATA_HI = IDX_W'(HDR_BYTES + NUM_REGS);

    link_state_e      state;
    octet_t           shreg;
    logic [2:0]       bit_cnt;
    logic [IDX_W-1:0] idx;
    logic             addr_phase;
    logic             is_read;
    logic             got_byte;
    logic             host_ack;
    logic             sda_oe;
    octet_t           tx_next;
    logic [IDX_W-1:0] idx_inc;

    // Saturating byte position so long transfers never wrap back in range.
    assign idx_inc = (idx == IDX_MAX) ? idx : idx + 1'b1;

    // Byte to send at read position idx: count, then registers, then 0xFF.
    always_comb begin
        tx_next = 8'hFF;
        if (idx == '0) tx_next = 8'(NUM_REGS);
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx == IDX_W'(k + 1)) tx_next = reg_flat[8*k +: 8];
        end
    end

    // Protocol sequencing; START and STOP take priority in every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            idx        <= '0;
            addr_phase <= 1'b0;
            is_read    <= 1'b0;
            got_byte   <= 1'b0;
            host_ack   <= 1'b0;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_sel     <= '0;
            wr_byte    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state      <= ST_RX;
                addr_phase <= 1'b1;
                got_byte   <= 1'b0;
                bit_cnt    <= '0;
                idx        <= '0;
                sda_oe     <= 1'b0;
            end else if (stop_evt) begin
                state    <= ST_IDLE;
                got_byte <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) got_byte <= 1'b1;
                        end else if (scl_fall && got_byte) begin
                            got_byte <= 1'b0;
                            if (addr_phase) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_RX_ACK;
                                if (idx >= DATA_LO && idx < DATA_HI) begin
                                    wr_en   <= 1'b1;
                                    wr_sel  <= REG_IW'(idx - DATA_LO);
                                    wr_byte <= shreg;
                                end
                                idx <= idx_inc;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt    <= '0;
                            addr_phase <= 1'b0;
                            if (addr_phase && is_read) begin
                                shreg  <= tx_next;
                                sda_oe <= ~tx_next[7];
                                idx    <= idx_inc;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b1};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg   <= tx_next;
                                sda_oe  <= ~tx_next[7];
                                idx     <= idx_inc;
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = sda_oe;

    // SDA pull may only move while SCL is seen low.
    assert_sda_moves_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl)
        else $error("SDA pull changed while SCL high");

    // An unaddressed slave never pulls SDA.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe)
        else $error("SDA pulled while idle");

    // STOP always returns the engine to idle.
    assert_stop_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE))
        else $error("STOP did not end transfer");

    // Stores only ever target an existing register.
    assert_store_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_sel) < NUM_REGS))
        else $error("store beyond register bank");

endmodule

// File: rtl/cfg_reg_file.sv
// Bank of byte-wide configuration registers with per-register reset
// values. Assumes at most one store per cycle from the protocol engine.
module cfg_reg_file
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int REG_IW   = 3,
    parameter logic [7:0] RST_FIRST = 8'h00,
    parameter logic [7:0] RST_REST  = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_IW-1:0]     wr_sel,
    input  octet_t                wr_byte,
    output logic [8*NUM_REGS-1:0] reg_flat
);
    function automatic logic [8*NUM_REGS-1:0] rst_image();
        logic [8*NUM_REGS-1:0] img;
        for (int k = 0; k < NUM_REGS; k++) img[8*k +: 8] = (k == 0) ? RST_FIRST : RST_REST;
        return img;
    endfunction

    localparam logic [8*NUM_REGS-1:0] RST_FLAT = rst_image();

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RV = RST_FLAT[8*g +: 8];
        octet_t q;
        // Holds one register; loads when the engine selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= RV;
            else if (wr_en && wr_sel == REG_IW'(g))    q <= wr_byte;
        end
        assign reg_flat[8*g +: 8] = q;
    end

    // Registers leave reset with their documented defaults.
    assert_reset_image_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_flat == RST_FLAT))
        else $error("reset image wrong");

    // Without a store the bank does not move.
    assert_hold_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat))
        else $error("register changed without store");

endmodule

// File: rtl/clkcfg_i2c_slave.sv
// Top of the block-transfer configuration slave: line sampler, protocol
// engine and register bank. Assumes an external open-drain pad turns
// sda_pull_low into a low level on SDA.
module clkcfg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] RST_FIRST   = 8'h00,
    parameter logic [7:0] RST_REST    = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    output logic [8*NUM_REGS-1:0] cfg_regs
);
    import clkcfg_pkg::*;

    localparam int REG_IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int IDX_W  = $clog2(NUM_REGS + 3) + 1;

    logic        scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic        wr_en;
    logic [REG_IW-1:0] wr_sel;
    octet_t      wr_byte;

    i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    cfg_link_fsm #(
        .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .REG_IW(REG_IW), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
        .stop_evt(stop_evt), .reg_flat(cfg_regs), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_byte(wr_byte), .sda_pull(sda_pull_low)
    );

    cfg_reg_file #(
        .NUM_REGS(NUM_REGS), .REG_IW(REG_IW), .RST_FIRST(RST_FIRST), .RST_REST(RST_REST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_byte(wr_byte), .reg_flat(cfg_regs)
    );

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
// Self-checking bench: wired-AND bus model, directed corner cases and
// seeded random transfers checked against a bench-side register model.
module clkcfg_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 6;
    localparam int NREG       = 6;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_host = 1'b1;
    logic sda_pull;
    logic sda_bus;
    logic [8*NREG-1:0] cfg;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int r12_viol = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [10];
    logic [3:0] scl_hist = 4'b0;
    logic prev_pull = 1'b0;

    assign sda_bus = sda_host & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_i2c_slave u_clkcfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull_low(sda_pull), .cfg_regs(cfg)
    );

    // R12 monitor: pull must not move after SCL has been high for a while.
    always @(negedge clk) begin
        if (rst_n && (&scl_hist) && scl && (sda_pull != prev_pull)) r12_viol++;
        scl_hist <= {scl_hist[2:0], scl};
        prev_pull <= sda_pull;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [8*NREG-1:0] model_flat();
        logic [8*NREG-1:0] f;
        for (int k = 0; k < NREG; k++) f[8*k +: 8] = model[k];
        return f;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        wt(PH); sda_host = 1'b1; wt(PH); scl = 1'b1; wt(PH); sda_host = 1'b0; wt(PH); scl = 1'b0;
    endtask

    task automatic stop_c();
        wt(PH); sda_host = 1'b0; wt(PH); scl = 1'b1; wt(PH); sda_host = 1'b1; wt(2*PH);
    endtask

    task automatic bit_io(input logic b, output logic s);
        wt(PH); sda_host = b; wt(PH); scl = 1'b1; wt(PH); s = sda_bus; wt(PH); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, ack_n);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(!give_ack, s);
    endtask

    // Write header plus n data bytes from wbuf, leaving the bus before STOP.
    task automatic write_body(input int n);
        logic a;
        send_byte(8'hD2, a);           chk(a == 1'b0, "R1 write address ack", a, 0);
        send_byte(8'($urandom), a);    chk(a == 1'b0, "R3 command byte ack", a, 0);
        send_byte(8'($urandom), a);    chk(a == 1'b0, "R3 count byte ack", a, 0);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            if (i < NREG) begin
                chk(a == 1'b0, "R4 data byte ack", a, 0);
                model[i] = wbuf[i];
            end else begin
                chk(a == 1'b0, "R6 surplus byte ack", a, 0);
            end
        end
    endtask

    task automatic do_write(input int n);
        start_c();
        write_body(n);
        stop_c();
        chk(cfg == model_flat(), "R4 image after write", cfg, model_flat());
    endtask

    // Read count plus k register positions, NACK on the last byte.
    task automatic do_read(input int k);
        logic a;
        logic [7:0] d;
        logic [7:0] e;
        start_c();
        send_byte(8'hD3, a);  chk(a == 1'b0, "R1 read address ack", a, 0);
        recv_byte(k > 0, d);  chk(d == 8'(NREG), "R7 count byte", d, NREG);
        for (int i = 0; i < k; i++) begin
            recv_byte(i < k - 1, d);
            e = (i < NREG) ? model[i] : 8'hFF;
            chk(d == e, "R7 register byte", d, e);
        end
        stop_c();
    endtask

    task automatic fill_wbuf();
        for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
    endtask

    initial begin
        logic a;
        logic s;
        logic [7:0] d;
        void'($urandom(32'd4711));
        model[0] = 8'h00;
        for (int k = 1; k < NREG; k++) model[k] = 8'hFF;

        wt(5);
        rst_n = 1'b1;
        wt(2);
        chk(cfg == 48'hFFFF_FFFF_FF00, "R9 reset image", cfg, 48'hFFFF_FFFF_FF00);
        chk(sda_pull == 1'b0, "R9 SDA released after reset", sda_pull, 0);

        // R3: header only leaves registers untouched.
        do_write(0);
        chk(cfg == 48'hFFFF_FFFF_FF00, "R3 header-only write no effect", cfg, 48'hFFFF_FFFF_FF00);

        // R4: full write then readback.
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
        wbuf[3] = 8'h78; wbuf[4] = 8'h9A; wbuf[5] = 8'hBC;
        do_write(6);
        do_read(6);

        // R6: surplus bytes discarded, R7 positions past end read 0xFF.
        fill_wbuf();
        do_write(9);
        do_read(8);

        // R5 and R10: short write restarts at register 0, rest untouched.
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        do_write(2);
        wbuf[0] = 8'h5C;
        do_write(1);
        chk(cfg[15:8] == 8'hA2, "R10 second write only reached reg0", cfg[15:8], 8'hA2);
        chk(cfg[7:0] == 8'h5C, "R10 reg0 rewritten", cfg[7:0], 8'h5C);

        // R5: byte cut by STOP after three bits is not stored.
        start_c();
        wbuf[0] = 8'h11;
        write_body(1);
        bit_io(1'b0, s); bit_io(1'b0, s); bit_io(1'b1, s);
        stop_c();
        chk(cfg == model_flat(), "R5 partial byte not stored", cfg, model_flat());

        // R2: mismatched address, then bytes that must not be acked.
        start_c();
        send_byte(8'hA4, a);  chk(a == 1'b1, "R2 wrong address nack", a, 1);
        send_byte(8'h00, a);  chk(a == 1'b1, "R2 silent after mismatch", a, 1);
        send_byte(8'h00, a);  chk(a == 1'b1, "R2 silent after mismatch", a, 1);
        stop_c();
        chk(cfg == model_flat(), "R2 registers unchanged", cfg, model_flat());
        start_c();
        send_byte(8'hD7, a);  chk(a == 1'b1, "R2 wrong read address nack", a, 1);
        recv_byte(1'b0, d);   chk(d == 8'hFF, "R2 no data driven", d, 8'hFF);
        stop_c();

        // R8: NACK on count byte, then further clocks see a released line.
        start_c();
        send_byte(8'hD3, a);  chk(a == 1'b0, "R8 read address ack", a, 0);
        recv_byte(1'b0, d);   chk(d == 8'(NREG), "R8 count before nack", d, NREG);
        recv_byte(1'b1, d);   chk(d == 8'hFF, "R8 SDA released after nack", d, 8'hFF);
        stop_c();

        // R11: repeated START switches a partial write into a read.
        start_c();
        wbuf[0] = 8'hE7;
        write_body(1);
        bit_io(1'b0, s); bit_io(1'b1, s);
        start_c();
        send_byte(8'hD3, a);  chk(a == 1'b0, "R11 address after repeated start", a, 0);
        recv_byte(1'b1, d);   chk(d == 8'(NREG), "R11 count after repeated start", d, NREG);
        recv_byte(1'b0, d);   chk(d == 8'hE7, "R11 reg0 kept from cut write", d, 8'hE7);
        stop_c();

        // Random mix of writes, reads and cut writes.
        for (int t = 0; t < 20; t++) begin
            int sel;
            sel = $urandom_range(0, 2);
            fill_wbuf();
            if (sel == 0) begin
                do_write($urandom_range(0, 8));
            end else if (sel == 1) begin
                do_read($urandom_range(0, 7));
            end else begin
                int nb;
                int pb;
                nb = $urandom_range(0, 6);
                pb = $urandom_range(1, 7);
                start_c();
                write_body(nb);
                for (int j = 0; j < pb; j++) bit_io(1'($urandom), s);
                stop_c();
                chk(cfg == model_flat(), "R5 random cut write", cfg, model_flat());
            end
        end
        do_read(6);

        chk(r12_viol == 0, "R12 SDA pull stable while SCL high", r12_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule